// File: doc/BRIEF.md
# Timer with Software Event Generation

A 16-bit counter core with a programmable prescaler, a reload limit and four capture/compare channels, plus a write-only event register through which software can force an update, a trigger, or a per-channel capture/compare event as though the matching hardware condition had occurred. The counter runs up, down, or center-aligned. Each channel is set either as an input (capture) or as an output (compare).

Forced events have side effects that depend on the mode:
- A forced update restarts the counter according to the count direction.
- A forced update clears the prescaler phase and moves the pending reload and prescale values into the active registers.
- A forced input event latches the counter and detects overcapture.
- A forced output event only raises the channel flag.

Status flags drive a masked interrupt line and a masked DMA request line. Software clears the flags by writing zeros.

Register map (4-bit address, 16-bit data):

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | [0] run, [2:1] mode (00 up, 01 down, 1x center-aligned), [3] reload preload enable |
| 1 | CHDIR | [3:0] channel direction, 1 = input capture for channels 1..4 |
| 2 | ENABLES | [6:0] interrupt enables, [14:8] DMA enables, using the same bit layout as the status register |
| 3 | STATUS | [0] update flag, [4:1] channel 1..4 flags, [6] trigger flag, [12:9] channel 1..4 overcapture flags |
| 4 | EVGEN | [0] update, [4:1] channels 1..4, [6] trigger; all other bits are ignored |
| 5 | PSC | Pending prescale factor; the count advances once every PSC+1 cycles |
| 6 | RELOAD | Reload value |
| 7 | COUNT | Counter, read only |
| 8..11 | CCR1..CCR4 | Channel 1..4 compare/capture values |

Top module: `evgen_timer`

## Requirements
- R1: After reset, STATUS, COUNT and the irq and dma_req outputs are all zero.
- R2: Address 4 always reads 0, and a write of 0 to it changes no state.
- R3: A forced update (EVGEN bit 0) sets COUNT to 0 in up and center-aligned modes, and to the RELOAD value in down mode. It also sets STATUS bit 0.
- R4: A forced update clears the prescaler phase, so the first count step after it comes PSC+1 cycles later.
- R5: An update event, forced or from wraparound, moves the pending PSC value, and the RELOAD value when preload is on, into the active registers.
- R6: A forced trigger (EVGEN bit 6) sets STATUS bit 6.
- R7: A forced event on an output channel sets only that channel's flag (STATUS bit 1..4). It leaves the CCR and the overcapture flag unchanged.
- R8: A forced event on an input channel copies COUNT into that channel's CCR and sets its flag.
- R9: A forced input capture while the channel flag is already set also sets that channel's overcapture flag (STATUS bits 9..12).
- R10: Writing STATUS clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R11: irq is high exactly when some STATUS bit 0..6 is set together with its interrupt enable. dma_req follows the same rule with the DMA enables.
- R12: A forced event takes effect on the clock edge after the write edge, not on the write edge.
- R13: In up mode the counter counts 0..RELOAD, then wraps to 0 and sets STATUS bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The forced update is tried in all three count modes from a nonzero count. The results separate a clear-to-zero from a load-of-reload, and a third value would show a mode being ignored.

A forced channel event is applied once to an output channel and once to an input channel, each twice in a row. Only the input channel may change its CCR and gain an overcapture flag.

With a prescale factor of 3, the count steps are timed after a forced update. This shows both that the phase was cleared and that the new factor took over.

Status writes with mixed bit patterns separate clear-on-zero from clear-on-write.

// File: rtl/evgen_timer.sv
module evgen_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [3:0]    rd_addr,
  output logic [15:0]   rd_data,
  output logic          irq,
  output logic          dma_req
);
  localparam int NCH = 4;

  logic          run, arpe;
  logic [1:0]    mode;
  logic [NCH-1:0] chdir;
  logic [6:0]    ien, den;
  logic [6:0]    flags;
  logic [NCH-1:0] ovf;
  logic [CW-1:0] psc_sh, psc_act, psc_cnt;
  logic [CW-1:0] arr_sh, arr_act, cnt;
  logic          dir_up;
  logic [CW-1:0] ccr [NCH];
  logic [6:0]    eg_q;

  wire is_dn  = !mode[1] && mode[0];
  wire is_ctr = mode[1];
  wire tick   = run && (psc_cnt == psc_act);
  wire [CW-1:0] arr_eff = arpe ? arr_act : arr_sh;

  logic hw_upd;
  always_comb begin
    if (is_ctr)     hw_upd = tick && !dir_up && (cnt == '0);
    else if (is_dn) hw_upd = tick && (cnt == '0);
    else            hw_upd = tick && (cnt == arr_eff);
  end

  wire upd = eg_q[0] | hw_upd;

  logic [NCH-1:0] cc_set, ovf_set;
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cc_set[i]  = eg_q[i+1] | (tick && !chdir[i] && (cnt == ccr[i]));
    assign ovf_set[i] = eg_q[i+1] & chdir[i] & flags[i+1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ccr[i] <= '0;
      else if (eg_q[i+1] && chdir[i])    ccr[i] <= cnt;
      else if (wr_en && wr_addr == 4'(8 + i)) ccr[i] <= wr_data[CW-1:0];
    end
  end

  wire [6:0] flag_set = {eg_q[6], 1'b0, cc_set, upd};
  wire st_wr = wr_en && (wr_addr == 4'd3);
  wire [6:0]     flag_keep = st_wr ? wr_data[6:0]  : 7'h7F;
  wire [NCH-1:0] ovf_keep  = st_wr ? wr_data[12:9] : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; arpe <= 1'b0; mode <= '0; chdir <= '0;
      ien <= '0; den <= '0; psc_sh <= '0; arr_sh <= '0;
      flags <= '0; ovf <= '0; eg_q <= '0;
    end else begin
      flags <= (flags & flag_keep) | flag_set;
      ovf   <= (ovf & ovf_keep) | ovf_set;
      eg_q  <= (wr_en && wr_addr == 4'd4) ? (wr_data[6:0] & 7'h5F) : '0;
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin run <= wr_data[0]; mode <= wr_data[2:1]; arpe <= wr_data[3]; end
          4'd1: chdir  <= wr_data[NCH-1:0];
          4'd2: begin ien <= wr_data[6:0]; den <= wr_data[14:8]; end
          4'd5: psc_sh <= wr_data[CW-1:0];
          4'd6: arr_sh <= wr_data[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; psc_cnt <= '0; dir_up <= 1'b1;
      psc_act <= '0; arr_act <= '0;
    end else begin
      if (upd) begin
        psc_act <= psc_sh;
        arr_act <= arr_sh;
      end
      if (eg_q[0]) begin
        psc_cnt <= '0;
        cnt     <= is_dn ? arr_sh : '0;
        dir_up  <= 1'b1;
      end else if (tick) begin
        psc_cnt <= '0;
        if (is_ctr) begin
          if (dir_up) begin
            if (cnt == arr_eff) begin
              dir_up <= 1'b0;
              cnt    <= (arr_eff == '0) ? '0 : cnt - 1'b1;
            end else cnt <= cnt + 1'b1;
          end else begin
            if (cnt == '0) begin
              dir_up <= 1'b1;
              cnt    <= (arr_eff == '0) ? '0 : CW'(1);
            end else cnt <= cnt - 1'b1;
          end
        end else if (is_dn) begin
          cnt <= (cnt == '0) ? arr_sh : cnt - 1'b1;
        end else begin
          cnt <= (cnt == arr_eff) ? '0 : cnt + 1'b1;
        end
      end else if (run) begin
        psc_cnt <= psc_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      4'd0:  rd_data = {12'd0, arpe, mode, run};
      4'd1:  rd_data = {12'd0, chdir};
      4'd2:  rd_data = {1'b0, den, 1'b0, ien};
      4'd3:  rd_data = {3'd0, ovf, 2'd0, flags};
      4'd5:  rd_data = 16'(psc_sh);
      4'd6:  rd_data = 16'(arr_sh);
      4'd7:  rd_data = 16'(cnt);
      4'd8:  rd_data = 16'(ccr[0]);
      4'd9:  rd_data = 16'(ccr[1]);
      4'd10: rd_data = 16'(ccr[2]);
      4'd11: rd_data = 16'(ccr[3]);
      default: rd_data = '0;
    endcase
  end

  assign irq     = |(flags & ien);
  assign dma_req = |(flags & den);
endmodule

// File: rtl/evgen_timer_chk.sv
module evgen_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic [3:0]  rd_addr,
  input logic [15:0] rd_data,
  input logic        irq,
  input logic        dma_req,
  input logic [6:0]  flags,
  input logic [3:0]  ovf,
  input logic [3:0]  chdir
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flags == 7'd0 && ovf == 4'd0));

  // R2
  evgen_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 4'd4) |-> (rd_data == 16'd0));

  // R6
  trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[6]) |-> $past(wr_en && wr_addr == 4'd4 && wr_data[6], 2));

  // R11
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 7'd0) |-> (!irq && !dma_req));

  for (genvar i = 0; i < 4; i++) begin : g_ov
    // R9
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[i]) |-> $past(flags[i+1]));
    // R7
    ovf_input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[i]) |-> $past(chdir[i]));
  end
endmodule

bind evgen_timer evgen_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .dma_req(dma_req),
  .flags(flags), .ovf(ovf), .chdir(chdir)
);

// File: tb/evgen_timer_tb.sv
module evgen_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq, dma_req;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evgen_timer u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(4'd3, v); chk("R1 status", v, 16'h0);
    rd(4'd7, v); chk("R1 count", v, 16'h0);
    chk("R1 irq/dma", {14'd0, irq, dma_req}, 16'h0);
  endtask

  task automatic t_evgen_read();
    logic [15:0] v;
    wr(4'd4, 16'h0000); step(2);
    rd(4'd3, v); chk("R2 zero write no effect", v, 16'h0);
    wr(4'd4, 16'h005F);
    rd(4'd4, v); chk("R2 evgen reads zero", v, 16'h0);
    step(1); wr(4'd3, 16'h0);
  endtask

  task automatic t_update_modes();
    logic [15:0] v;
    wr(4'd6, 16'd100); wr(4'd0, 16'h0001); step(10); wr(4'd0, 16'h0000);
    rd(4'd7, v); chk("R3 up count advanced", {15'd0, v != 0}, 16'h1);
    wr(4'd3, 16'h0);
    wr(4'd4, 16'h0001);
    rd(4'd7, v); chk("R12 update not yet applied", {15'd0, v != 0}, 16'h1);
    rd(4'd3, v); chk("R12 flag not yet", v, 16'h0);
    step(1);
    rd(4'd7, v); chk("R3 up clears count", v, 16'h0);
    rd(4'd3, v); chk("R3 update flag", v & 16'h1, 16'h1);
    wr(4'd0, 16'h0002); wr(4'd4, 16'h0001); step(1);
    rd(4'd7, v); chk("R3 down loads reload", v, 16'd100);
    wr(4'd0, 16'h0005); step(7); wr(4'd0, 16'h0004);
    rd(4'd7, v); chk("R3 center count advanced", {15'd0, v != 0}, 16'h1);
    wr(4'd4, 16'h0001); step(1);
    rd(4'd7, v); chk("R3 center clears count", v, 16'h0);
    wr(4'd3, 16'h0);
  endtask

  task automatic t_prescaler();
    logic [15:0] v;
    wr(4'd6, 16'd1000); wr(4'd5, 16'd3); wr(4'd0, 16'h0001); step(20);
    rd(4'd7, v); chk("R5 old factor still active", {15'd0, v > 16'd15}, 16'h1);
    wr(4'd4, 16'h0001); step(1);
    rd(4'd7, v); chk("R4 count zero after update", v, 16'h0);
    step(3); rd(4'd7, v); chk("R4 no step before PSC+1", v, 16'h0);
    step(1); rd(4'd7, v); chk("R4 first step", v, 16'd1);
    step(4); rd(4'd7, v); chk("R5 new factor", v, 16'd2);
    wr(4'd0, 16'h0000); wr(4'd5, 16'd0); wr(4'd4, 16'h0001); step(1);
    wr(4'd3, 16'h0);
  endtask

  task automatic t_trigger_irq();
    logic [15:0] v;
    wr(4'd2, 16'h0000); wr(4'd3, 16'h0);
    wr(4'd4, 16'h0040);
    rd(4'd3, v); chk("R12 trigger not yet", v, 16'h0);
    step(1);
    rd(4'd3, v); chk("R6 trigger flag", v, 16'h0040);
    chk("R11 masked irq", {15'd0, irq}, 16'h0);
    wr(4'd2, 16'h0040);
    chk("R11 irq enabled", {14'd0, irq, dma_req}, 16'h2);
    wr(4'd2, 16'h4000);
    chk("R11 dma enabled", {14'd0, irq, dma_req}, 16'h1);
    wr(4'd2, 16'h0002);
    chk("R11 other enable only", {14'd0, irq, dma_req}, 16'h0);
    wr(4'd2, 16'h0000); wr(4'd3, 16'h0);
  endtask

  task automatic t_out_channel();
    logic [15:0] v;
    wr(4'd1, 16'h0); wr(4'd8, 16'h1234); wr(4'd3, 16'h0);
    wr(4'd4, 16'h0002); step(1);
    rd(4'd3, v); chk("R7 output flag only", v, 16'h0002);
    wr(4'd4, 16'h0002); step(1);
    rd(4'd3, v); chk("R7 no overcapture on output", v, 16'h0002);
    rd(4'd8, v); chk("R7 ccr unchanged", v, 16'h1234);
    wr(4'd3, 16'h0);
  endtask

  task automatic t_in_capture();
    logic [15:0] v;
    wr(4'd1, 16'h8); wr(4'd0, 16'h0002); wr(4'd6, 16'h0ABC);
    wr(4'd4, 16'h0001); step(1); wr(4'd3, 16'h0);
    wr(4'd4, 16'h0010); step(1);
    rd(4'd11, v); chk("R8 capture value", v, 16'h0ABC);
    rd(4'd3, v);  chk("R8 capture flag", v, 16'h0010);
    wr(4'd4, 16'h0010); step(1);
    rd(4'd3, v);  chk("R9 overcapture", v, 16'h1010);
  endtask

  task automatic t_status_clear();
    logic [15:0] v;
    wr(4'd4, 16'h0041); step(1);
    rd(4'd3, v); chk("R10 preset", v, 16'h1051);
    wr(4'd3, 16'hFFFF);
    rd(4'd3, v); chk("R10 ones keep", v, 16'h1051);
    wr(4'd3, 16'hEFEF);
    rd(4'd3, v); chk("R10 selective clear", v, 16'h0041);
    wr(4'd3, 16'h0000);
    rd(4'd3, v); chk("R10 full clear", v, 16'h0);
    wr(4'd1, 16'h0);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(4'd8, 16'h00FF);
    wr(4'd0, 16'h0000); wr(4'd6, 16'd3); wr(4'd4, 16'h0001); step(1);
    wr(4'd3, 16'h0);
    wr(4'd0, 16'h0001);
    rd(4'd7, v); chk("R13 start", v, 16'd0);
    step(3);
    rd(4'd7, v); chk("R13 at reload", v, 16'd3);
    rd(4'd3, v); chk("R13 no flag before wrap", v & 16'h1, 16'h0);
    step(1);
    rd(4'd7, v); chk("R13 wrapped", v, 16'd0);
    rd(4'd3, v); chk("R13 wrap flag", v & 16'h1, 16'h1);
    wr(4'd0, 16'h0000);
  endtask

  initial begin
    step(3); rst_n = 1'b1; step(1);
    t_reset();
    t_evgen_read();
    t_update_modes();
    t_prescaler();
    t_trigger_irq();
    t_out_channel();
    t_in_capture();
    t_status_clear();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule